// File: doc/BRIEF.md
# Dual-Clock Mailbox Exchange

This block gives two independently clocked ports a pair of 36-bit message registers for control or status words. Port A posts words into mailbox 1, which port B reads. Port B posts words into mailbox 2, which port A reads. Every access is timed by the clock of the port that makes it. The written word is therefore held in the writer's clock domain, and the reader samples it on its own clock.

Each port has three controls: a mailbox select, an enable and a direction bit. An access happens on a rising edge of that port's clock when select and enable are both high. The direction bit chooses whether the access posts a word or fetches one.

Each mailbox has a new-mail indicator in the reader's clock domain. A post raises it and a fetch by the reader lowers it. The indicator only reports state and never blocks a post or a fetch.

Top module: `xport_mailbox`

## Requirements
- R1: After the asynchronous reset rst_ni is released, both new-mail indicators and both read-data outputs are 0.
- R2: A port A access with select=1, enable=1 and direction=1 (write) stores a_wdata_i in mailbox 1. The next port B access with select=1, enable=1 and direction=0 (read) presents that word on b_rdata_o after the clk_b edge.
- R3: A port B write (select=1, enable=1, direction=1) stores b_wdata_i in mailbox 2. The next port A read presents that word on a_rdata_o after the clk_a edge.
- R4: After a write to a mailbox, its indicator (b_mail_o for mailbox 1, a_mail_o for mailbox 2) stays 0 at the first reader-clock falling edge. It is 1 within four rising edges of the reader's clock.
- R5: A read by the reader's port clears that mailbox's indicator on the same reader-clock edge, unless new mail arrives in that same cycle.
- R6: An access with enable=0 or select=0 does nothing. Mailbox contents, indicators and read-data outputs stay unchanged. A read-data output changes only on a read.
- R7: The indicator never gates an access. A write while the indicator is set replaces the word. A read while it is clear still returns the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| a_sel_i | input | 1 | Port A mailbox select |
| a_en_i | input | 1 | Port A enable |
| a_wr_i | input | 1 | Port A direction: 1 write mailbox 1, 0 read mailbox 2 |
| a_wdata_i | input | 36 | Port A word to post |
| a_rdata_o | output | 36 | Word last fetched from mailbox 2 |
| a_mail_o | output | 1 | Mailbox 2 holds unread mail |
| b_sel_i | input | 1 | Port B mailbox select |
| b_en_i | input | 1 | Port B enable |
| b_wr_i | input | 1 | Port B direction: 1 write mailbox 2, 0 read mailbox 1 |
| b_wdata_i | input | 36 | Port B word to post |
| b_rdata_o | output | 36 | Word last fetched from mailbox 1 |
| b_mail_o | output | 1 | Mailbox 1 holds unread mail |

## Verification
The assertions assume the writer does not post to a mailbox again while the reader is still fetching it. The reason is that the data word crosses domains without synchronizing flops. The indicator checks use the internal new-mail pulse, so a set in the same cycle as a read is allowed. The stimulus keeps to this rule. For each mailbox it posts once, waits until the indicator is seen in the reader's domain, and then fetches before the next post. Random data and random gating of select and enable are mixed with directed cases: a gated-off access, a double post, and a read with no mail pending. The two clocks run at unrelated periods.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int unsigned XMB_DW = 36;
  localparam int unsigned XMB_SYNC = 2;

  typedef enum logic {
    XMB_READ  = 1'b0,
    XMB_WRITE = 1'b1
  } xmb_dir_e;

  function automatic logic xmb_hit(input logic sel, input logic en, input logic dir, input xmb_dir_e want);
    return sel & en & (dir == logic'(want));
  endfunction
endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[s] <= 1'b0;
      else if (s == 0) sr_q[s] <= d_i;
      else sr_q[s] <= sr_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/xmb_slot.sv
module xmb_slot #(
  parameter int unsigned DW          = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          mail_o,
  output logic          set_o
);
  logic [DW-1:0] data_q;
  logic          tog_q;
  logic          tog_s;
  logic          seen_q;
  logic          mail_q;
  logic [DW-1:0] rdata_q;

  // writer domain: word plus toggle event
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      tog_q  <= 1'b0;
    end else if (wr_i) begin
      data_q <= wdata_i;
      tog_q  <= ~tog_q;
    end
  end

  xmb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (tog_q),
    .q_o    (tog_s)
  );

  assign set_o = tog_s ^ seen_q;

  // reader domain; data_q is quiet once the toggle has landed
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      mail_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      seen_q <= tog_s;
      if (set_o)     mail_q <= 1'b1;
      else if (rd_i) mail_q <= 1'b0;
      if (rd_i) rdata_q <= data_q;
    end
  end

  assign rdata_o = rdata_q;
  assign mail_o  = mail_q;
endmodule

// File: rtl/xport_mailbox.sv
module xport_mailbox
  import xmb_pkg::*;
#(
  parameter int unsigned DW          = XMB_DW,
  parameter int unsigned SYNC_STAGES = XMB_SYNC
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          a_sel_i,
  input  logic          a_en_i,
  input  logic          a_wr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic          a_mail_o,
  input  logic          b_sel_i,
  input  logic          b_en_i,
  input  logic          b_wr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          b_mail_o
);
  logic a_wr_hit, a_rd_hit, b_wr_hit, b_rd_hit;
  logic mb1_set, mb2_set;

  assign a_wr_hit = xmb_hit(a_sel_i, a_en_i, a_wr_i, XMB_WRITE);
  assign a_rd_hit = xmb_hit(a_sel_i, a_en_i, a_wr_i, XMB_READ);
  assign b_wr_hit = xmb_hit(b_sel_i, b_en_i, b_wr_i, XMB_WRITE);
  assign b_rd_hit = xmb_hit(b_sel_i, b_en_i, b_wr_i, XMB_READ);

  // mailbox 1: A -> B
  xmb_slot #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
    .wclk_i  (clk_a_i),
    .rclk_i  (clk_b_i),
    .rst_ni  (rst_ni),
    .wr_i    (a_wr_hit),
    .wdata_i (a_wdata_i),
    .rd_i    (b_rd_hit),
    .rdata_o (b_rdata_o),
    .mail_o  (b_mail_o),
    .set_o   (mb1_set)
  );

  // mailbox 2: B -> A
  xmb_slot #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
    .wclk_i  (clk_b_i),
    .rclk_i  (clk_a_i),
    .rst_ni  (rst_ni),
    .wr_i    (b_wr_hit),
    .wdata_i (b_wdata_i),
    .rd_i    (a_rd_hit),
    .rdata_o (a_rdata_o),
    .mail_o  (a_mail_o),
    .set_o   (mb2_set)
  );
endmodule

// File: rtl/xport_mailbox_chk.sv
module xport_mailbox_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic          a_sel_i,
  input logic          a_en_i,
  input logic          a_wr_i,
  input logic [DW-1:0] a_rdata_o,
  input logic          a_mail_o,
  input logic          b_sel_i,
  input logic          b_en_i,
  input logic          b_wr_i,
  input logic [DW-1:0] b_rdata_o,
  input logic          b_mail_o,
  input logic          mb1_set_i,
  input logic          mb2_set_i
);
  logic a_rd, b_rd;
  assign a_rd = a_sel_i & a_en_i & ~a_wr_i;
  assign b_rd = b_sel_i & b_en_i & ~b_wr_i;

  // R4: a landed event raises the indicator on the next edge
  p_set_b_r4: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    mb1_set_i |=> b_mail_o);
  p_set_a_r4: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    mb2_set_i |=> a_mail_o);
  p_rise_b_r4: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $rose(b_mail_o) |-> $past(mb1_set_i));
  p_rise_a_r4: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $rose(a_mail_o) |-> $past(mb2_set_i));

  // R5: reader fetch clears the indicator
  p_clear_b_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_rd && !mb1_set_i) |=> !b_mail_o);
  p_clear_a_r5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_rd && !mb2_set_i) |=> !a_mail_o);

  // R6: read data moves only on a read
  p_hold_b_r6: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !b_rd |=> $stable(b_rdata_o));
  p_hold_a_r6: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_rd |=> $stable(a_rdata_o));
endmodule

bind xport_mailbox xport_mailbox_chk #(.DW(DW)) u_chk (
  .clk_a_i   (clk_a_i),
  .clk_b_i   (clk_b_i),
  .rst_ni    (rst_ni),
  .a_sel_i   (a_sel_i),
  .a_en_i    (a_en_i),
  .a_wr_i    (a_wr_i),
  .a_rdata_o (a_rdata_o),
  .a_mail_o  (a_mail_o),
  .b_sel_i   (b_sel_i),
  .b_en_i    (b_en_i),
  .b_wr_i    (b_wr_i),
  .b_rdata_o (b_rdata_o),
  .b_mail_o  (b_mail_o),
  .mb1_set_i (mb1_set),
  .mb2_set_i (mb2_set)
);

// File: tb/xport_mailbox_bench.sv
`timescale 1ns/1ps
module xport_mailbox_bench;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_sel = 0, a_en = 0, a_wr = 0, b_sel = 0, b_en = 0, b_wr = 0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_mail, b_mail;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] mb1_model = '0, mb2_model = '0;
  logic mb1_flag = 0, mb2_flag = 0;
  logic [DW-1:0] a_last = '0, b_last = '0;
  bit done = 0;

  always #5 clk_a = ~clk_a;
  always #8.5 clk_b = ~clk_b;

  xport_mailbox u_xport_mailbox (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_sel_i(a_sel), .a_en_i(a_en), .a_wr_i(a_wr), .a_wdata_i(a_wdata),
    .a_rdata_o(a_rdata), .a_mail_o(a_mail),
    .b_sel_i(b_sel), .b_en_i(b_en), .b_wr_i(b_wr), .b_wdata_i(b_wdata),
    .b_rdata_o(b_rdata), .b_mail_o(b_mail)
  );

  function automatic bit effective(input logic s, input logic e);
    return s && e;
  endfunction

  function automatic logic [DW-1:0] rnd36();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_write(input logic s, input logic e, input logic [DW-1:0] d);
    @(negedge clk_a);
    a_sel = s; a_en = e; a_wr = 1'b1; a_wdata = d;
    @(negedge clk_a);
    a_sel = 0; a_en = 0; a_wr = 0;
    if (effective(s, e)) begin mb1_model = d; mb1_flag = 1; end
  endtask

  task automatic b_write(input logic s, input logic e, input logic [DW-1:0] d);
    @(negedge clk_b);
    b_sel = s; b_en = e; b_wr = 1'b1; b_wdata = d;
    @(negedge clk_b);
    b_sel = 0; b_en = 0; b_wr = 0;
    if (effective(s, e)) begin mb2_model = d; mb2_flag = 1; end
  endtask

  task automatic b_read(input logic s, input logic e);
    @(negedge clk_b);
    b_sel = s; b_en = e; b_wr = 1'b0;
    @(negedge clk_b);
    b_sel = 0; b_en = 0;
    if (effective(s, e)) begin b_last = mb1_model; mb1_flag = 0; end
  endtask

  task automatic a_read(input logic s, input logic e);
    @(negedge clk_a);
    a_sel = s; a_en = e; a_wr = 1'b0;
    @(negedge clk_a);
    a_sel = 0; a_en = 0;
    if (effective(s, e)) begin a_last = mb2_model; mb2_flag = 0; end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_a);
    repeat (6) @(negedge clk_b);
  endtask

  task automatic check_all(input string req);
    check({req, " b_mail"}, DW'(b_mail), DW'(mb1_flag));
    check({req, " a_mail"}, DW'(a_mail), DW'(mb2_flag));
    check({req, " b_rdata"}, b_rdata, b_last);
    check({req, " a_rdata"}, a_rdata, a_last);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_a);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_a);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_b);
    check_all("R1 reset");

    // R2 / R4 / R5 directed
    d = 36'h9_A5A5_0F0F;
    a_write(1, 1, d);
    @(negedge clk_b);
    check("R4 not early", DW'(b_mail), DW'(0));
    repeat (5) @(negedge clk_b);
    check("R4 set", DW'(b_mail), DW'(1));
    b_read(1, 1);
    check("R2 data", b_rdata, d);
    check("R5 clear", DW'(b_mail), DW'(0));

    // R3
    d = 36'hF_0000_0001;
    b_write(1, 1, d);
    settle();
    check("R4 set a", DW'(a_mail), DW'(1));
    a_read(1, 1);
    check("R3 data", a_rdata, d);
    check("R5 clear a", DW'(a_mail), DW'(0));

    // R6 gated accesses
    a_write(1, 0, 36'h1_2345_6789);
    a_write(0, 1, 36'h2_3456_789A);
    b_write(0, 1, 36'h3_3333_3333);
    settle();
    check_all("R6 gated write");
    a_write(1, 1, 36'h4_4444_4444);
    settle();
    b_read(0, 1);
    b_read(1, 0);
    check_all("R6 gated read");
    b_read(1, 1);
    check_all("R6 then R2");

    // R7 double write and read with no mail
    a_write(1, 1, 36'h5_5555_5555);
    settle();
    a_write(1, 1, 36'hA_AAAA_AAAA);
    settle();
    check("R7 still set", DW'(b_mail), DW'(1));
    b_read(1, 1);
    check("R7 second word", b_rdata, 36'hA_AAAA_AAAA);
    b_read(1, 1);
    check("R7 read without mail", b_rdata, 36'hA_AAAA_AAAA);
    check("R7 flag clear", DW'(b_mail), DW'(0));

    // random mix
    for (int i = 0; i < 40; i++) begin
      a_write(($urandom() % 4) != 0, ($urandom() % 4) != 0, rnd36());
      b_write(($urandom() % 4) != 0, ($urandom() % 4) != 0, rnd36());
      settle();
      check_all("R2 R3 R4 random");
      b_read(1, ($urandom() % 3) != 0);
      a_read(($urandom() % 3) != 0, 1);
      check_all("R5 R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule